// File: doc/BRIEF.md
# Carry-Select Chained Arithmetic Cluster

This block is a 20-bit arithmetic slice made of ten cascaded 2-bit adder cells. Every sum bit adds the outputs of two configurable 4-input lookup tables, so the operands seen by the adders are arbitrary functions of the raw inputs and not the raw inputs themselves. Inside each cell the 2-bit sum and carry are computed twice, once for each possible incoming carry. The carry arriving from the previous cell then picks one of the two results.

The chain can begin at cell 0, which covers all 20 bits. It can also begin at cell 5, which covers bits 19:10. In that case the lower cells take no part in the sum. An add/subtract control and a carry-in feed the chain. A counter mode feeds the registered result back as operand A and a one at the chain's least significant bit as operand B. The result is offered unregistered and also through a register that has a clock enable and a synchronous clear. The final carry-out is a plain output.

Top module: `arith_cluster`

## Requirements
- R1: With `start_sel`=0, `{cout, sum_comb}` equals the sum over bits 0..19 of (TA_i + TB_i) weighted by 2^i, plus the effective carry-in. TA_i and TB_i are the outputs of bit i's A and B tables. The effective carry-in is `cin` when `sub`=0 and `cnt_en`=0.
- R2: Bit i's A table is `cfg_a[16*i +: 16]` and its B table is `cfg_b[16*i +: 16]`. A table's output is the table bit at index {sub_eff, aux[i], b[i], a[i]}, where a[i] is index bit 0 and sub_eff is index bit 3.
- R3: With `start_sel`=1, `sum_comb[9:0]` is zero. `{cout, sum_comb[19:10]}` is the same weighted sum taken over bits 10..19, with the carry-in entering at bit 10. Operands, aux and tables of bits 0..9 have no effect on any output.
- R4: With `sub`=1 and `cnt_en`=0, the effective carry-in is 1 whatever `cin` is, and sub_eff=1. Tables set to A=a and B=b XOR sub_eff (A table 16'hAAAA, B table 16'h33CC) give A minus B modulo 2^20, with `cout`=1 when A is at least B.
- R5: `sum_q` updates only on a rising clock edge with `ce`=1. It loads 0 if `sclr`=1 and `sum_comb` otherwise. With `ce`=0 it holds, and `sclr` then has no effect.
- R6: With `cnt_en`=1, a[i]=sum_q[i], b[i] is 1 only at the chain's least significant bit (bit 0, or bit 10 when `start_sel`=1), aux[i]=0, sub_eff=`cnt_dn`, and the effective carry-in is `cnt_dn`. The inputs `opa`, `opb`, `aux`, `sub` and `cin` are ignored. With the standard tables of R4 the chain region counts up by one (`cnt_dn`=0) or down by one (`cnt_dn`=1) per enabled edge, wrapping at the region's width.
- R7: Synchronous active-high `rst` sets `sum_q` to 0.
- R8: In every cell the result chosen for an incoming carry of 1 equals the result for an incoming carry of 0 plus one. `cout` is the carry out of cell 9 for either start position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 20 | Raw operand A, one bit per sum bit |
| opb | input | 20 | Raw operand B, one bit per sum bit |
| aux | input | 20 | Extra per-bit table input |
| cfg_a | input | 320 | A-side 16-entry truth tables, bit i at 16*i |
| cfg_b | input | 320 | B-side 16-entry truth tables, bit i at 16*i |
| cin | input | 1 | External carry-in |
| start_sel | input | 1 | 0: chain starts at cell 0; 1: at cell 5 |
| sub | input | 1 | Subtract control |
| cnt_en | input | 1 | Counter mode enable |
| cnt_dn | input | 1 | Counter direction, 1 counts down |
| ce | input | 1 | Clock enable of the result register |
| sclr | input | 1 | Synchronous clear, qualified by ce |
| sum_comb | output | 20 | Unregistered sum |
| sum_q | output | 20 | Registered sum |
| cout | output | 1 | Carry out of the last cell |

## Verification
`sum_comb` and `cout` are combinational and are due within the same cycle as their inputs. The bench drives them on a falling edge and samples a few nanoseconds later, before the next rising edge. `sum_q` is due one rising edge after the inputs that load it. The bench therefore drives on a falling edge, lets exactly one rising edge pass and samples on the following falling edge. Counter runs advance one step per edge, and each step is checked on the falling edge after it. Expected values come from a bench-side weighted sum of table outputs over the active bit range.

// File: rtl/arith_cluster_pkg.sv
package arith_cluster_pkg;

    localparam int unsigned N_CELLS    = 10;
    localparam int unsigned CELL_BITS  = 2;
    localparam int unsigned ALT_CELL   = 5;
    localparam int unsigned LUT_INPUTS = 4;
    localparam int unsigned TBL_W      = 1 << LUT_INPUTS;
    localparam int unsigned SUM_W      = N_CELLS * CELL_BITS;

    typedef enum logic {
        START_CELL0 = 1'b0,
        START_ALT   = 1'b1
    } start_e;

    // Lookup index of one pre-adder table; a is the least significant bit
    typedef struct packed {
        logic sub;
        logic aux;
        logic b;
        logic a;
    } lut_idx_t;

    // Control after the counter-mode override
    typedef struct packed {
        logic sub_eff;
        logic cin_eff;
    } chain_ctl_t;

    function automatic logic lut_eval(input logic [TBL_W-1:0] tbl, input lut_idx_t idx);
        return tbl[idx];
    endfunction

endpackage

// File: rtl/preadd_bit.sv
module preadd_bit
    import arith_cluster_pkg::*;
#(
    parameter int unsigned TW = TBL_W
) (
    input  logic [TW-1:0] tbl_a,
    input  logic [TW-1:0] tbl_b,
    input  lut_idx_t      idx,
    output logic          pa,
    output logic          pb
);

    assign pa = lut_eval(tbl_a, idx);
    assign pb = lut_eval(tbl_b, idx);

endmodule

// File: rtl/cs_cell.sv
module cs_cell #(
    parameter int unsigned CB = 2
) (
    input  logic [CB-1:0] pa,
    input  logic [CB-1:0] pb,
    input  logic          cin,
    output logic [CB-1:0] s,
    output logic          cout
);

    logic [CB:0] res_c0;
    logic [CB:0] res_c1;

    // Both carry-in cases are formed in parallel, then selected
    always_comb begin
        res_c0 = {1'b0, pa} + {1'b0, pb};
        res_c1 = {1'b0, pa} + {1'b0, pb} + {{CB{1'b0}}, 1'b1};
    end

    assign {cout, s} = cin ? res_c1 : res_c0;

    // R8: the carry-in-one result is the carry-in-zero result plus one
    always_comb begin
        if (!$isunknown({pa, pb})) begin
            a_r8_select_pair: assert (res_c1 == res_c0 + {{CB{1'b0}}, 1'b1})
                else $error("carry-select pair inconsistent");
        end
    end

endmodule

// File: rtl/carry_chain.sv
module carry_chain
    import arith_cluster_pkg::*;
#(
    parameter int unsigned NC  = N_CELLS,
    parameter int unsigned CB  = CELL_BITS,
    parameter int unsigned ALT = ALT_CELL,
    localparam int unsigned W  = NC * CB
) (
    input  logic [W-1:0] pa,
    input  logic [W-1:0] pb,
    input  logic         cin,
    input  start_e       start,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [NC:0]   cy;
    logic [W-1:0]  raw_sum;

    for (genvar k = 0; k < NC; k++) begin : g_cell
        logic cell_cin;

        if (k == 0) begin : g_first
            assign cell_cin = cin;
        end else if (k == ALT) begin : g_alt
            assign cell_cin = (start == START_ALT) ? cin : cy[k];
        end else begin : g_mid
            assign cell_cin = cy[k];
        end

        cs_cell #(.CB(CB)) u_cell (
            .pa   (pa[k*CB +: CB]),
            .pb   (pb[k*CB +: CB]),
            .cin  (cell_cin),
            .s    (raw_sum[k*CB +: CB]),
            .cout (cy[k+1])
        );

        if (k < ALT) begin : g_lowmask
            assign sum[k*CB +: CB] = (start == START_ALT) ? '0 : raw_sum[k*CB +: CB];
        end else begin : g_pass
            assign sum[k*CB +: CB] = raw_sum[k*CB +: CB];
        end
    end

    assign cy[0] = cin;
    assign cout  = cy[NC];

    // R3: excluded cells never contribute sum bits
    always_comb begin
        if (start == START_ALT) begin
            a_r3_low_cells_quiet: assert (sum[ALT*CB-1:0] == '0)
                else $error("excluded cells drive the sum");
        end
    end

endmodule

// File: rtl/arith_cluster.sv
module arith_cluster
    import arith_cluster_pkg::*;
#(
    parameter int unsigned NC  = N_CELLS,
    parameter int unsigned CB  = CELL_BITS,
    parameter int unsigned ALT = ALT_CELL,
    parameter int unsigned TW  = TBL_W,
    localparam int unsigned W  = NC * CB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [W-1:0]  aux,
    input  logic [W*TW-1:0] cfg_a,
    input  logic [W*TW-1:0] cfg_b,
    input  logic          cin,
    input  logic          start_sel,
    input  logic          sub,
    input  logic          cnt_en,
    input  logic          cnt_dn,
    input  logic          ce,
    input  logic          sclr,
    output logic [W-1:0]  sum_comb,
    output logic [W-1:0]  sum_q,
    output logic          cout
);

    start_e       start;
    chain_ctl_t   ctl;
    logic [W-1:0] lsb_vec;
    logic [W-1:0] eff_a, eff_b, eff_aux;
    logic [W-1:0] pa, pb;

    assign start   = start_e'(start_sel);
    assign lsb_vec = (start == START_ALT) ? (W'(1) << (ALT*CB)) : W'(1);

    // Counter mode replaces the raw inputs with feedback and a unit step
    always_comb begin
        if (cnt_en) begin
            eff_a       = sum_q;
            eff_b       = lsb_vec;
            eff_aux     = '0;
            ctl.sub_eff = cnt_dn;
            ctl.cin_eff = cnt_dn;
        end else begin
            eff_a       = opa;
            eff_b       = opb;
            eff_aux     = aux;
            ctl.sub_eff = sub;
            ctl.cin_eff = sub | cin;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        lut_idx_t idx;
        assign idx = '{sub: ctl.sub_eff, aux: eff_aux[i], b: eff_b[i], a: eff_a[i]};

        preadd_bit #(.TW(TW)) u_pre (
            .tbl_a (cfg_a[i*TW +: TW]),
            .tbl_b (cfg_b[i*TW +: TW]),
            .idx   (idx),
            .pa    (pa[i]),
            .pb    (pb[i])
        );
    end

    carry_chain #(.NC(NC), .CB(CB), .ALT(ALT)) u_chain (
        .pa    (pa),
        .pb    (pb),
        .cin   (ctl.cin_eff),
        .start (start),
        .sum   (sum_comb),
        .cout  (cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else if (ce) begin
            sum_q <= sclr ? '0 : sum_comb;
        end
    end

    a_r7_reset_clears: assert property (@(posedge clk) rst |=> (sum_q == '0))
        else $error("reset did not clear");

    a_r5_hold_without_ce: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(sum_q))
        else $error("register moved without enable");

    a_r5_sclr_zero: assert property (@(posedge clk) disable iff (rst)
        (ce && sclr) |=> (sum_q == '0))
        else $error("sync clear ignored");

    a_r5_load_sum: assert property (@(posedge clk) disable iff (rst)
        (ce && !sclr) |=> (sum_q == $past(sum_comb)))
        else $error("register did not capture sum");

endmodule

// File: tb/tb_arith_cluster.sv
module tb_arith_cluster;

    localparam int W  = 20;
    localparam int TW = 16;

    logic          clk = 0;
    logic          rst;
    logic [W-1:0]  opa, opb, aux;
    logic [W*TW-1:0] cfg_a, cfg_b;
    logic          cin, start_sel, sub, cnt_en, cnt_dn, ce, sclr;
    logic [W-1:0]  sum_comb, sum_q;
    logic          cout;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    arith_cluster dut (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .aux(aux),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cin(cin), .start_sel(start_sel),
        .sub(sub), .cnt_en(cnt_en), .cnt_dn(cnt_dn), .ce(ce), .sclr(sclr),
        .sum_comb(sum_comb), .sum_q(sum_q), .cout(cout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Weighted sum of table outputs over the active bit range
    function automatic logic [20:0] model();
        int lo = start_sel ? 10 : 0;
        logic [31:0] tot = 0;
        logic cin_e = sub | cin;
        for (int i = lo; i < W; i++) begin
            int idx = {sub, aux[i], opb[i], opa[i]};
            tot += ({31'b0, cfg_a[i*TW + idx]} + {31'b0, cfg_b[i*TW + idx]}) << i;
        end
        tot += {31'b0, cin_e} << lo;
        return tot[20:0];
    endfunction

    task automatic std_tables();
        cfg_a = {W{16'hAAAA}};
        cfg_b = {W{16'h33CC}};
    endtask

    task automatic rand_tables();
        for (int k = 0; k < W*TW/32; k++) begin
            cfg_a[k*32 +: 32] = $urandom;
            cfg_b[k*32 +: 32] = $urandom;
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #3;
    endtask

    task automatic t_reset();
        rst = 1; ce = 0; sclr = 0; cnt_en = 0; cnt_dn = 0;
        sub = 0; cin = 0; start_sel = 0; opa = 0; opb = 0; aux = 0;
        std_tables();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset value", {12'b0, sum_q}, 32'h0);
        rst = 0;
    endtask

    task automatic t_add_std();
        std_tables(); sub = 0; start_sel = 0;
        opa = 20'h12345; opb = 20'h0ABCD; cin = 0; settle();
        chk("R1 add sum", {11'b0, cout, sum_comb}, {11'b0, 21'h12345 + 21'h0ABCD});
        opa = 20'hFFFFF; opb = 20'h00000; cin = 1; settle();
        chk("R1 R8 full carry ripple", {11'b0, cout, sum_comb}, {11'b0, 21'h100000});
        opa = 20'hAAAAA; opb = 20'h55555; cin = 0; settle();
        chk("R1 alternating no carry", {11'b0, cout, sum_comb}, {11'b0, 21'h0FFFFF});
    endtask

    task automatic t_field();
        cfg_a = '0; cfg_b = '0; cfg_a[6] = 1'b1; sub = 0; cin = 0; start_sel = 0;
        opa = 0; opb = 20'h1; aux = 20'h1; settle();
        chk("R2 index 6 selects table bit", {12'b0, sum_comb}, 32'h1);
        aux = 0; settle();
        chk("R2 aux is index bit 2", {12'b0, sum_comb}, 32'h0);
        aux = 0;
    endtask

    task automatic t_random(input bit st);
        for (int t = 0; t < 25; t++) begin
            rand_tables();
            opa = $urandom; opb = $urandom; aux = $urandom;
            cin = $urandom; sub = $urandom; start_sel = st;
            settle();
            chk(st ? "R3 random tables upper start" : "R1 R2 random tables",
                {11'b0, cout, sum_comb}, {11'b0, model()});
        end
    endtask

    task automatic t_start_hi();
        logic [20:0] ref_v;
        rand_tables(); start_sel = 1; sub = 0; cin = 1;
        opa = $urandom; opb = $urandom; aux = $urandom; settle();
        ref_v = model();
        chk("R3 low bits zero", {22'b0, sum_comb[9:0]}, 32'h0);
        opa[9:0] = ~opa[9:0]; opb[9:0] = $urandom; aux[9:0] = ~aux[9:0];
        cfg_a[159:0] = ~cfg_a[159:0];
        settle();
        chk("R3 lower inputs ignored", {11'b0, cout, sum_comb}, {11'b0, ref_v});
        std_tables(); opa = 20'hFFC00; opb = 20'h00000; cin = 1; settle();
        chk("R3 R8 upper wrap carry", {11'b0, cout, sum_comb}, {11'b0, 21'h100000});
    endtask

    task automatic t_sub();
        std_tables(); start_sel = 0; sub = 1;
        opa = 20'd5; opb = 20'd7; cin = 0; settle();
        chk("R4 5-7 borrow", {11'b0, cout, sum_comb}, {11'b0, 1'b0, 20'hFFFFE});
        cin = 1; settle();
        chk("R4 cin ignored in subtract", {11'b0, cout, sum_comb}, {11'b0, 1'b0, 20'hFFFFE});
        opa = 20'd7; opb = 20'd5; settle();
        chk("R4 7-5 no borrow", {11'b0, cout, sum_comb}, {11'b0, 1'b1, 20'h00002});
        sub = 0; cin = 0;
    endtask

    task automatic load(input logic [W-1:0] v);
        @(negedge clk);
        std_tables(); sub = 0; cin = 0; cnt_en = 0; opa = v; opb = 0; ce = 1; sclr = 0;
        @(negedge clk);
        ce = 0;
    endtask

    task automatic t_reg();
        start_sel = 0;
        load(20'h3C3C3);
        chk("R5 load sum", {12'b0, sum_q}, 32'h3C3C3);
        opa = 20'h11111; ce = 0; sclr = 1;
        @(negedge clk);
        chk("R5 hold without ce, sclr ignored", {12'b0, sum_q}, 32'h3C3C3);
        ce = 1; sclr = 1;
        @(negedge clk);
        chk("R5 sync clear", {12'b0, sum_q}, 32'h0);
        ce = 0; sclr = 0;
    endtask

    task automatic t_counter();
        start_sel = 0;
        load(20'hFFFFE);
        cnt_en = 1; cnt_dn = 0; ce = 1;
        opa = 20'h5A5A5; opb = 20'hFFFFF; aux = 20'hFFFFF; sub = 1; cin = 1;
        @(negedge clk);
        chk("R6 count up", {12'b0, sum_q}, 32'hFFFFF);
        @(negedge clk);
        chk("R6 count up wrap", {12'b0, sum_q}, 32'h0);
        cnt_dn = 1;
        @(negedge clk);
        chk("R6 count down wrap", {12'b0, sum_q}, 32'hFFFFF);
        ce = 0;
        @(negedge clk);
        chk("R5 R6 counter holds without ce", {12'b0, sum_q}, 32'hFFFFF);
        cnt_en = 0; cnt_dn = 0; sub = 0; cin = 0; aux = 0;
        start_sel = 1;
        load(20'hFFC00);
        cnt_en = 1; cnt_dn = 0; ce = 1;
        @(negedge clk);
        chk("R6 upper region count wraps", {12'b0, sum_q}, 32'h0);
        cnt_dn = 1;
        @(negedge clk);
        chk("R6 upper region count down", {12'b0, sum_q}, 32'hFFC00);
        @(negedge clk);
        chk("R6 upper region second step", {12'b0, sum_q}, 32'hFF800);
        ce = 0; cnt_en = 0; cnt_dn = 0;
    endtask

    initial begin
        t_reset();
        t_add_std();
        t_field();
        t_random(1'b0);
        t_random(1'b1);
        t_start_hi();
        t_sub();
        t_reg();
        t_counter();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule